// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the address and byte-count engine of a single DMA channel. A start pulse loads a source pointer, a destination pointer and a byte count. The block then issues read beats that fill the channel FIFO and write beats that empty it. Each beat is an address plus a size code, held until the bus side returns a one-cycle done. The FIFO is modelled only as a fill counter; the data path lives elsewhere.

Reads are grouped into bursts of a programmed length. Once a burst is in the FIFO, the FIFO is drained to the destination before the next burst starts. Beat sizes shrink to fit what is left, both on the read side and on the write side. A request-select code picks one of three modes: memory-to-memory, peripheral receive or peripheral transmit. The two peripheral modes pin the address on the peripheral side of the transfer.

A buffer ends when its count is exhausted and the FIFO is empty. At that point the channel either reloads all three pointers from shadow inputs and keeps running, or it goes idle and drops its enable. A sticky interrupt-pending flag records buffer completion and the fall of the channel status, each under its own enable.

Top module: `dseq_channel`

## Requirements
- R1: After reset `busy_o`, `enable_o` and `ipend_o` are 0, and neither `rd_req_o` nor `wr_req_o` is asserted.
- R2: A `go_i` pulse while idle loads the source pointer, destination pointer and count, and raises `busy_o` and `enable_o` on the same clock edge. The first read beat is presented at the loaded source address. A read or write beat stays presented with stable address and size until its done input is sampled high.
- R3: A read beat's size code (0 = byte, 1 = halfword, 2 = word; code 3 acts as word) is the source width. It is reduced to the largest of 1, 2 or 4 bytes that does not exceed the remaining count or the bytes left in the current burst.
- R4: A write beat's size code (same encoding) is the destination width, reduced to the largest of 1, 2 or 4 bytes that does not exceed the FIFO fill.
- R5: After each completed beat, a pointer advances by that beat's byte count when its increment enable is set, and stays put otherwise.
- R6: Request-select 0 is memory-to-memory, and reads proceed without `periph_req_i`. Values 1 to 31 are peripheral receive: source increment is forced off. Values 32 to 63 (top bit set) are peripheral transmit: destination increment is forced off. In both peripheral modes, read beats wait for `periph_req_i`.
- R7: A burst reads `burst_i`+1 bytes, or fewer if the count runs out first. All of those bytes are written out before the next read beat is issued.
- R8: With reload disabled, once the count is zero and the FIFO is empty, `busy_o` falls and `enable_o` clears on the same edge.
- R9: With reload enabled at count-to-zero, the source, destination and count are loaded from the reload inputs. `busy_o` stays 1 and reads continue at the reload source address.
- R10: `ipend_o` is set at count-to-zero when `ctz_ie_i` is 1, and when `busy_o` falls when `chd_ie_i` is 1. With both enables 0 it stays 0.
- R11: `ipend_o` stays set until a cycle with `ipend_clr_i` high, after which it is 0.
- R12: A `go_i` pulse while the channel is busy is ignored: the pointers are not reloaded from the program inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start pulse; sets enable and loads pointers when idle |
| ipend_clr_i | input | 1 | Write-one-to-clear strobe for the pending flag |
| periph_req_i | input | 1 | Peripheral DMA request |
| reload_en_i | input | 1 | Reload at count-to-zero |
| ctz_ie_i | input | 1 | Count-to-zero interrupt enable |
| chd_ie_i | input | 1 | Channel-idle interrupt enable |
| src_inc_i | input | 1 | Source increment enable |
| dst_inc_i | input | 1 | Destination increment enable |
| req_sel_i | input | SEL_W | Request select |
| src_width_i | input | 2 | Source width code |
| dst_width_i | input | 2 | Destination width code |
| burst_i | input | BURST_W | Burst length minus one, in bytes |
| src_addr_i | input | ADDR_W | Programmed source address |
| dst_addr_i | input | ADDR_W | Programmed destination address |
| cnt_i | input | CNT_W | Programmed byte count |
| src_rld_i | input | ADDR_W | Source reload value |
| dst_rld_i | input | ADDR_W | Destination reload value |
| cnt_rld_i | input | CNT_W | Count reload value |
| rd_req_o | output | 1 | Read beat valid |
| rd_addr_o | output | ADDR_W | Read beat address |
| rd_size_o | output | 2 | Read beat size code |
| rd_done_i | input | 1 | Read beat completed |
| wr_req_o | output | 1 | Write beat valid |
| wr_addr_o | output | ADDR_W | Write beat address |
| wr_size_o | output | 2 | Write beat size code |
| wr_done_i | input | 1 | Write beat completed |
| busy_o | output | 1 | Channel status |
| enable_o | output | 1 | Channel enable |
| ipend_o | output | 1 | Interrupt pending |

## Verification
Pointer, count and fill updates land on the edge that samples a beat's done. The next beat's address and size are visible in the half-cycle after that edge. The bench responder therefore records each beat at the falling edge where it raises done, which fixes the order of reads against writes. Status, enable and the pending flag change on the edge that retires the last write, plus one cycle for the empty-FIFO decision. The bench waits at falling edges for `busy_o` to drop and checks all three there. A start pulse shows its effect at the first falling edge after the loading edge, and the bench checks there.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_st_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/dseq_fit.sv
// Picks the largest beat (1, 2 or 4 bytes) within the programmed width and
// the bytes available (avail_i is saturated to 4 by the caller).
module dseq_fit
    import dseq_pkg::*;
(
    input  logic [1:0] width_i,
    input  logic [2:0] avail_i,
    output logic [1:0] size_o,
    output logic [2:0] bytes_o
);
    logic [1:0] want;

    always_comb begin
        want = (width_i == 2'd3) ? SZ_WORD : width_i;
        if (want == SZ_WORD && avail_i >= 3'd4) begin
            size_o = SZ_WORD;
        end else if (want != SZ_BYTE && avail_i >= 3'd2) begin
            size_o = SZ_HALF;
        end else begin
            size_o = SZ_BYTE;
        end
        bytes_o = 3'b001 << size_o;
    end
endmodule

// File: rtl/dseq_reqdec.sv
// Classifies the request select: zero is memory-to-memory, top bit set is a
// peripheral transmit target, anything else is a peripheral receive source.
module dseq_reqdec #(
    parameter int SEL_W = 6
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic             mem2mem_o,
    output logic             prx_o,
    output logic             ptx_o
);
    always_comb begin
        mem2mem_o = (sel_i == '0);
        ptx_o     = sel_i[SEL_W-1];
        prx_o     = !mem2mem_o && !sel_i[SEL_W-1];
    end
endmodule

// File: rtl/dseq_channel.sv
module dseq_channel
    import dseq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int BURST_W = 5,
    parameter int SEL_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic               ipend_clr_i,
    input  logic               periph_req_i,
    input  logic               reload_en_i,
    input  logic               ctz_ie_i,
    input  logic               chd_ie_i,
    input  logic               src_inc_i,
    input  logic               dst_inc_i,
    input  logic [SEL_W-1:0]   req_sel_i,
    input  logic [1:0]         src_width_i,
    input  logic [1:0]         dst_width_i,
    input  logic [BURST_W-1:0] burst_i,
    input  logic [ADDR_W-1:0]  src_addr_i,
    input  logic [ADDR_W-1:0]  dst_addr_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [ADDR_W-1:0]  src_rld_i,
    input  logic [ADDR_W-1:0]  dst_rld_i,
    input  logic [CNT_W-1:0]   cnt_rld_i,
    output logic               rd_req_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic [1:0]         rd_size_o,
    input  logic               rd_done_i,
    output logic               wr_req_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [1:0]         wr_size_o,
    input  logic               wr_done_i,
    output logic               busy_o,
    output logic               enable_o,
    output logic               ipend_o
);
    localparam int LVL_W = BURST_W + 1;

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [LVL_W-1:0]  level;
        logic [LVL_W-1:0]  bleft;
        logic              enable;
        logic              busy;
        logic              ipend;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic             mem2mem, prx, ptx;
    logic             src_inc_eff, dst_inc_eff, req_active;
    logic [LVL_W-1:0] burst_len;
    logic [2:0]       cnt_sat, bleft_sat, lvl_sat;
    logic [1:0]       fit_w  [2];
    logic [2:0]       fit_av [2];
    logic [1:0]       fit_sz [2];
    logic [2:0]       fit_b  [2];
    logic             ctz_ev, fall_ev;
    logic [CNT_W-1:0] cnt_cur;
    logic [LVL_W-1:0] level_cur;

    dseq_reqdec #(.SEL_W(SEL_W)) u_reqdec (
        .sel_i     (req_sel_i),
        .mem2mem_o (mem2mem),
        .prx_o     (prx),
        .ptx_o     (ptx)
    );

    // Index 0 sizes read beats, index 1 sizes write beats.
    for (genvar g = 0; g < 2; g++) begin : g_fit
        dseq_fit u_fit (
            .width_i (fit_w[g]),
            .avail_i (fit_av[g]),
            .size_o  (fit_sz[g]),
            .bytes_o (fit_b[g])
        );
    end

    always_comb begin
        src_inc_eff = src_inc_i && !prx;
        dst_inc_eff = dst_inc_i && !ptx;
        req_active  = mem2mem || periph_req_i;
        burst_len   = LVL_W'(burst_i) + LVL_W'(1);

        cnt_sat   = (state_q.cnt   >= CNT_W'(4)) ? 3'd4 : state_q.cnt[2:0];
        bleft_sat = (state_q.bleft >= LVL_W'(4)) ? 3'd4 : state_q.bleft[2:0];
        lvl_sat   = (state_q.level >= LVL_W'(4)) ? 3'd4 : state_q.level[2:0];

        fit_w[0]  = src_width_i;
        fit_av[0] = (cnt_sat < bleft_sat) ? cnt_sat : bleft_sat;
        fit_w[1]  = dst_width_i;
        fit_av[1] = lvl_sat;
    end

    assign rd_req_o  = (state_q.st == ST_READ) && (state_q.cnt != '0) &&
                       (state_q.bleft != '0) && req_active;
    assign rd_addr_o = state_q.src;
    assign rd_size_o = fit_sz[0];
    assign wr_req_o  = (state_q.st == ST_WRITE) && (state_q.level != '0);
    assign wr_addr_o = state_q.dst;
    assign wr_size_o = fit_sz[1];
    assign busy_o    = state_q.busy;
    assign enable_o  = state_q.enable;
    assign ipend_o   = state_q.ipend;
    assign cnt_cur   = state_q.cnt;
    assign level_cur = state_q.level;

    always_comb begin
        state_d = state_q;
        ctz_ev  = 1'b0;
        fall_ev = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    state_d.src    = src_addr_i;
                    state_d.dst    = dst_addr_i;
                    state_d.cnt    = cnt_i;
                    state_d.level  = '0;
                    state_d.bleft  = burst_len;
                    state_d.enable = 1'b1;
                    state_d.busy   = 1'b1;
                    state_d.st     = ST_READ;
                end
            end
            ST_READ: begin
                if (state_q.cnt == '0 || state_q.bleft == '0) begin
                    state_d.st = ST_WRITE;
                end else if (rd_req_o && rd_done_i) begin
                    if (src_inc_eff) begin
                        state_d.src = state_q.src + ADDR_W'(fit_b[0]);
                    end
                    state_d.cnt   = state_q.cnt - CNT_W'(fit_b[0]);
                    state_d.level = state_q.level + LVL_W'(fit_b[0]);
                    state_d.bleft = state_q.bleft - LVL_W'(fit_b[0]);
                end
            end
            ST_WRITE: begin
                if (state_q.level == '0) begin
                    state_d.bleft = burst_len;
                    if (state_q.cnt != '0) begin
                        state_d.st = ST_READ;
                    end else begin
                        ctz_ev = 1'b1;
                        if (reload_en_i) begin
                            state_d.src = src_rld_i;
                            state_d.dst = dst_rld_i;
                            state_d.cnt = cnt_rld_i;
                            state_d.st  = ST_READ;
                        end else begin
                            fall_ev        = 1'b1;
                            state_d.busy   = 1'b0;
                            state_d.enable = 1'b0;
                            state_d.st     = ST_IDLE;
                        end
                    end
                end else if (wr_done_i) begin
                    if (dst_inc_eff) begin
                        state_d.dst = state_q.dst + ADDR_W'(fit_b[1]);
                    end
                    state_d.level = state_q.level - LVL_W'(fit_b[1]);
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
        state_d.ipend = (state_q.ipend && !ipend_clr_i) ||
                        (ctz_ev && ctz_ie_i) || (fall_ev && chd_ie_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: ST_IDLE, src: '0, dst: '0, cnt: '0, level: '0,
                         bleft: '0, enable: 1'b0, busy: 1'b0, ipend: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/dseq_channel_chk.sv
module dseq_channel_chk #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int BURST_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req_o,
    input logic [1:0]         rd_size_o,
    input logic               wr_req_o,
    input logic               wr_done_i,
    input logic [ADDR_W-1:0]  wr_addr_o,
    input logic [1:0]         wr_size_o,
    input logic               busy_o,
    input logic               enable_o,
    input logic               ipend_o,
    input logic               ipend_clr_i,
    input logic [CNT_W-1:0]   cnt_cur,
    input logic [BURST_W:0]   level_cur
);
    logic [2:0] rd_bytes, wr_bytes;
    assign rd_bytes = 3'b001 << rd_size_o;
    assign wr_bytes = 3'b001 << wr_size_o;

    // R1: no beat is presented while the channel is idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_req_o && !wr_req_o));

    // R2: a pending write beat holds address and size until done
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_done_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_size_o)));

    // R3: a read beat never exceeds the remaining count
    a_r3_rd_fits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (CNT_W'(rd_bytes) <= cnt_cur));

    // R4: a write beat never exceeds the FIFO fill
    a_r4_wr_fits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> ((BURST_W+1)'(wr_bytes) <= level_cur));

    // R7: the FIFO fill never passes the largest burst
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_cur <= {1'b1, {BURST_W{1'b0}}});

    // R8: the enable clears when status falls
    a_r8_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !enable_o);

    // R11: the pending flag is sticky
    a_r11_ipend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ipend_o && !ipend_clr_i) |=> ipend_o);

    // R11: a clear strobe while idle empties the pending flag
    a_r11_ipend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ipend_clr_i && !busy_o) |=> !ipend_o);
endmodule

bind dseq_channel dseq_channel_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .BURST_W(BURST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_o   (rd_req_o),
    .rd_size_o  (rd_size_o),
    .wr_req_o   (wr_req_o),
    .wr_done_i  (wr_done_i),
    .wr_addr_o  (wr_addr_o),
    .wr_size_o  (wr_size_o),
    .busy_o     (busy_o),
    .enable_o   (enable_o),
    .ipend_o    (ipend_o),
    .ipend_clr_i(ipend_clr_i),
    .cnt_cur    (cnt_cur),
    .level_cur  (level_cur)
);

// File: tb/dseq_channel_tb.sv
module dseq_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 0, ipend_clr_i = 0, periph_req_i = 0, reload_en_i = 0;
    logic        ctz_ie_i = 0, chd_ie_i = 0, src_inc_i = 0, dst_inc_i = 0;
    logic [5:0]  req_sel_i = '0;
    logic [1:0]  src_width_i = '0, dst_width_i = '0;
    logic [4:0]  burst_i = '0;
    logic [31:0] src_addr_i = '0, dst_addr_i = '0, src_rld_i = '0, dst_rld_i = '0;
    logic [23:0] cnt_i = '0, cnt_rld_i = '0;
    logic        rd_req_o, wr_req_o, busy_o, enable_o, ipend_o;
    logic        rd_done_i = 0, wr_done_i = 0;
    logic [31:0] rd_addr_o, wr_addr_o;
    logic [1:0]  rd_size_o, wr_size_o;

    int n_checks = 0, n_fail = 0, seq = 0, rd_n = 0, wr_n = 0;
    logic        finished = 0;
    logic [31:0] rd_a [64];
    logic [1:0]  rd_s [64];
    int          rd_q [64];
    logic [31:0] wr_a [64];
    logic [1:0]  wr_s [64];
    int          wr_q [64];

    dseq_channel dut_i (.*);

    always #5 clk = ~clk;

    // Bus responder: each falling edge with a beat presented completes it at
    // the next rising edge; the beat is logged here in issue order.
    always @(negedge clk) begin
        rd_done_i = rd_req_o;
        wr_done_i = wr_req_o;
        if (rd_req_o && rd_n < 64) begin
            rd_a[rd_n] = rd_addr_o; rd_s[rd_n] = rd_size_o; rd_q[rd_n] = seq;
            rd_n++; seq++;
        end
        if (wr_req_o && wr_n < 64) begin
            wr_a[wr_n] = wr_addr_o; wr_s[wr_n] = wr_size_o; wr_q[wr_n] = seq;
            wr_n++; seq++;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic clear_logs();
        rd_n = 0; wr_n = 0; seq = 0;
    endtask

    task automatic start(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c);
        @(negedge clk);
        src_addr_i = s; dst_addr_i = d; cnt_i = c; go_i = 1;
        @(negedge clk);
        go_i = 0;
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        while (busy_o && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(!busy_o, {tag, " channel finished"}, 32'(busy_o), 0);
    endtask

    task automatic clr_ipend();
        @(negedge clk); ipend_clr_i = 1;
        @(negedge clk); ipend_clr_i = 0;
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", 32'(busy_o), 0);
        chk_eq("R1 enable", 32'(enable_o), 0);
        chk_eq("R1 ipend", 32'(ipend_o), 0);
        chk_eq("R1 no beats", 32'({rd_req_o, wr_req_o}), 0);
    endtask

    task automatic t_word_copy();
        clear_logs();
        req_sel_i = 0; src_width_i = 2; dst_width_i = 2; src_inc_i = 1; dst_inc_i = 1;
        burst_i = 31; ctz_ie_i = 1; chd_ie_i = 0; reload_en_i = 0;
        start(32'h100, 32'h200, 24'd10);
        chk_eq("R2 busy after go", 32'(busy_o), 1);
        chk_eq("R2 enable after go", 32'(enable_o), 1);
        chk_eq("R2 first read addr", rd_addr_o, 32'h100);
        wait_idle("R8");
        chk_eq("R3 read count", rd_n, 3);
        chk_eq("R3 rd0 size", 32'(rd_s[0]), 2);
        chk_eq("R3 rd2 shrunk to half", 32'(rd_s[2]), 1);
        chk_eq("R5 rd2 addr", rd_a[2], 32'h108);
        chk_eq("R4 wr2 shrunk to half", 32'(wr_s[2]), 1);
        chk_eq("R5 wr1 addr", wr_a[1], 32'h204);
        chk_eq("R8 enable cleared", 32'(enable_o), 0);
        chk_eq("R10 ipend on count-to-zero", 32'(ipend_o), 1);
        repeat (5) @(negedge clk);
        chk_eq("R11 ipend sticky", 32'(ipend_o), 1);
        clr_ipend();
        chk_eq("R11 ipend cleared", 32'(ipend_o), 0);
    endtask

    task automatic t_burst();
        clear_logs();
        req_sel_i = 0; src_width_i = 0; dst_width_i = 2; src_inc_i = 1; dst_inc_i = 1;
        burst_i = 2; ctz_ie_i = 0; chd_ie_i = 0;
        start(32'h300, 32'h400, 24'd5);
        wait_idle("R7");
        chk_eq("R7 reads", rd_n, 5);
        chk_eq("R4 writes", wr_n, 3);
        chk_eq("R4 wr0 half", 32'(wr_s[0]), 1);
        chk_eq("R4 wr1 byte", 32'(wr_s[1]), 0);
        chk_eq("R5 wr1 addr", wr_a[1], 32'h402);
        chk_eq("R5 wr2 addr", wr_a[2], 32'h403);
        chk(rd_q[2] < wr_q[0], "R7 burst read before drain", rd_q[2], wr_q[0]);
        chk(wr_q[1] < rd_q[3], "R7 drain before next burst", wr_q[1], rd_q[3]);
        chk_eq("R10 no ipend when disabled", 32'(ipend_o), 0);
    endtask

    task automatic t_periph_rx();
        clear_logs();
        req_sel_i = 6'd5; src_width_i = 1; dst_width_i = 1; src_inc_i = 1; dst_inc_i = 1;
        burst_i = 31; ctz_ie_i = 0; chd_ie_i = 1; periph_req_i = 0;
        start(32'h500, 32'h600, 24'd4);
        repeat (6) @(negedge clk);
        chk_eq("R6 no read without request", rd_n, 0);
        start(32'hF00, 32'hF80, 24'd8);
        periph_req_i = 1;
        wait_idle("R6");
        periph_req_i = 0;
        chk_eq("R12 go while busy ignored", rd_a[0], 32'h500);
        chk_eq("R12 count kept", rd_n, 2);
        chk_eq("R6 rx src not incremented", rd_a[1], 32'h500);
        chk_eq("R6 rx dst incremented", wr_a[1], 32'h602);
        chk_eq("R10 ipend on status fall", 32'(ipend_o), 1);
        clr_ipend();
    endtask

    task automatic t_periph_tx();
        clear_logs();
        req_sel_i = 6'd40; src_width_i = 0; dst_width_i = 0; src_inc_i = 1; dst_inc_i = 1;
        burst_i = 31; ctz_ie_i = 0; chd_ie_i = 0; periph_req_i = 1;
        start(32'h700, 32'h780, 24'd3);
        wait_idle("R6");
        periph_req_i = 0;
        chk_eq("R6 tx src incremented", rd_a[2], 32'h702);
        chk_eq("R6 tx dst held", wr_a[2], 32'h780);
    endtask

    task automatic t_no_inc();
        clear_logs();
        req_sel_i = 0; src_width_i = 0; dst_width_i = 0; src_inc_i = 0; dst_inc_i = 0;
        burst_i = 31;
        start(32'hA00, 32'hB00, 24'd2);
        wait_idle("R5");
        chk_eq("R5 src held", rd_a[1], 32'hA00);
        chk_eq("R5 dst held", wr_a[1], 32'hB00);
    endtask

    task automatic t_reload();
        logic dropped = 0;
        int k = 0;
        clear_logs();
        req_sel_i = 0; src_width_i = 0; dst_width_i = 0; src_inc_i = 1; dst_inc_i = 1;
        burst_i = 31; ctz_ie_i = 1; chd_ie_i = 0; reload_en_i = 1;
        src_rld_i = 32'h800; dst_rld_i = 32'h900; cnt_rld_i = 24'd3;
        start(32'h100, 32'h200, 24'd2);
        while (wr_n < 5 && k < 3000) begin
            if (rd_n >= 3) reload_en_i = 0;
            if (!busy_o) dropped = 1;
            @(negedge clk);
            k++;
        end
        chk_eq("R9 stayed busy across reload", 32'(dropped), 0);
        wait_idle("R9");
        chk_eq("R9 reads", rd_n, 5);
        chk_eq("R9 reload src", rd_a[2], 32'h800);
        chk_eq("R9 reload src advance", rd_a[4], 32'h802);
        chk_eq("R9 reload dst", wr_a[2], 32'h900);
        chk_eq("R10 ipend after reload run", 32'(ipend_o), 1);
        clr_ipend();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_word_copy();
        t_burst();
        t_periph_rx();
        t_periph_tx();
        t_no_inc();
        t_reload();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule